// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Block

This block is the I/O register window of a two-channel disk bus-master DMA controller. It decodes a 16-byte region into one 8-byte slice per channel. Each slice holds a command byte, a status byte and a 32-bit descriptor-table base pointer. The command and pointer values drive the DMA engine through plain output pins. The engine drives plain inputs that report channel activity and raise the error and interrupt events.

The register bus is a plain strobe interface with no back-pressure: `bus_wr` or `bus_rd` is held for one cycle together with `bus_addr`, `bus_size` and `bus_wdata`. A write takes effect at that clock edge. Read data appears on `bus_rdata` with `bus_rvalid` high exactly one cycle later. Data is right-justified: bits 7:0 of `bus_wdata` and `bus_rdata` carry the byte at `bus_addr`, whatever the access width. `bus_rd` and `bus_wr` are never raised in the same cycle.

The status byte combines three kinds of bits. Bit 0 is owned by hardware. Bits 1 and 2 are events that software clears by writing one. Bits 5 and 6 are plain read/write flags. The command byte and the status byte accept only single-byte accesses.

Top module: `bmdma_regwin`

## Requirements
- R1: After reset every command bit, status bit and pointer bit is zero: `cmd_start`, `cmd_dir` and `prd_base` are 0, and every register reads back 0.
- R2: `bus_addr[3]` selects the channel. `bus_addr[2]`=0 selects the command/status bytes and `bus_addr[2]`=1 selects the pointer. In the command/status bytes, a byte access at offset 0 is the command byte and offset 2 is the status byte. A byte read at offset 1 or 3 returns 0xFF, and a byte write there changes nothing.
- R3: `bus_size` encodes 0 as 1 byte, 1 as 2 bytes, 2 as 4 bytes and 3 as 4 bytes. A command/status access wider than one byte does not reach a register: a read returns 0x0000FFFF for 2 bytes and 0xFFFFFFFF for 4 bytes, and a write changes nothing.
- R4: A status write loads bits 6:5 from the written byte. It clears bit 1 and bit 2 wherever the written bit is 1 and keeps them where it is 0. It leaves bit 0 alone. Bits 7, 4 and 3 always read 0.
- R5: A hardware set pulse (`hw_err_set` for bit 1, `hw_irq_set` for bit 2) wins over a software clear of the same bit in the same cycle.
- R6: Status bit 0 holds the value of `hw_active` sampled at the previous clock edge.
- R7: Command bit 0 is start and drives `cmd_start`. Command bit 3 is direction and drives `cmd_dir`. Both outputs change at the edge that takes the write. All other command bits read 0.
- R8: The pointer accepts 1-, 2- and 4-byte accesses at any byte offset and writes only the bytes that fall inside its 4 bytes. Bits 1:0 are dropped on write and read as 0. A read returns the pointer shifted down by 8×offset and masked to the access width.
- R9: Each channel has its own register state. An access to one channel never changes the other channel's registers or outputs.
- R10: `bus_rvalid` is high exactly in the cycle after `bus_rd`. Reads change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address in the window |
| bus_size | input | 2 | Access width code |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Right-justified write data |
| bus_rdata | output | 32 | Right-justified read data |
| bus_rvalid | output | 1 | Read data valid |
| hw_active | input | 2 | Per-channel activity from the engine |
| hw_err_set | input | 2 | Per-channel error event pulse |
| hw_irq_set | input | 2 | Per-channel interrupt event pulse |
| cmd_start | output | 2 | Per-channel start control |
| cmd_dir | output | 2 | Per-channel transfer direction |
| prd_base | output | 64 | Per-channel descriptor pointer, channel 0 in bits 31:0 |

## Verification
The bench writes all 256 values to the status byte of each channel with both event bits armed and `hw_active` toggled. A design that treats bits 1 and 2 as plain read/write, or that lets a write reach bit 0 or bits 7, 4 and 3, returns a wrong status byte. Wide accesses and the odd byte offsets of the command/status bytes are tried for both reads and writes. A design that decodes them as registers returns wrong read data or corrupts the command byte. Byte and half-word writes at every pointer offset, including the 2-byte write at offset 3 that runs past the end, catch wrong lane masking and a stored bits 1:0. Event pulses that coincide with a software clear, and a status read issued in the same cycle as an activity change, catch a clear that wins over a set and a bit 0 that does not lag by one cycle.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int REG_W      = 32;
  localparam int SLICE_BYTES = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // byte lanes touched by an access of the given width at a byte offset
  function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] off);
    logic [6:0] m;
    case (size)
      SZ_BYTE: m = 7'b0000001;
      SZ_HALF: m = 7'b0000011;
      default: m = 7'b0001111;
    endcase
    m = m << off;
    return m[3:0];
  endfunction

  function automatic logic [REG_W-1:0] width_ones(input logic [1:0] size);
    case (size)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/bmdma_status.sv
module bmdma_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_clr,
  input  logic [1:0] wr_cap,
  input  logic       hw_active,
  input  logic       hw_err_set,
  input  logic       hw_irq_set,
  output logic [7:0] stat_q
);
  logic       act_q, err_q, irq_q;
  logic [1:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
      cap_q <= 2'b00;
    end else begin
      act_q <= hw_active;
      err_q <= hw_err_set | (err_q & ~(wr_en & wr_clr[0]));
      irq_q <= hw_irq_set | (irq_q & ~(wr_en & wr_clr[1]));
      if (wr_en) cap_q <= wr_cap;
    end
  end

  assign stat_q = {1'b0, cap_q, 2'b00, irq_q, err_q, act_q};

  assert_w1c_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_clr[0] && !hw_err_set) |=> !err_q);
  assert_w1c_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_clr[1] && !hw_irq_set) |=> !irq_q);
  assert_err_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hw_err_set |=> err_q);
  assert_irq_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hw_irq_set |=> irq_q);
  assert_active_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hw_active) |=> act_q);
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic             sub,
  input  logic [1:0]       off,
  input  logic [1:0]       size,
  input  logic [REG_W-1:0] wdata,
  input  logic             hw_active,
  input  logic             hw_err_set,
  input  logic             hw_irq_set,
  output logic [REG_W-1:0] rdata,
  output logic             start,
  output logic             dir,
  output logic [REG_W-1:0] base
);
  localparam int LANES = REG_W / 8;

  logic             byte_acc, wr_cs, wr_cmd, wr_stat, wr_base;
  logic [1:0]       cmd_q;
  logic [7:0]       stat;
  logic [REG_W-3:0] base_q;
  logic [LANES-1:0] lanes;
  logic [REG_W-1:0] lane_bits, wr_shift, base_nx;

  assign byte_acc = (size == SZ_BYTE);
  assign wr_cs    = sel & wr & ~sub & byte_acc;
  assign wr_cmd   = wr_cs & (off == 2'd0);
  assign wr_stat  = wr_cs & (off == 2'd2);
  assign wr_base  = sel & wr & sub;

  // command: bit 0 start, bit 3 direction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= 2'b00;
    else if (wr_cmd) cmd_q <= {wdata[3], wdata[0]};
  end
  assign start = cmd_q[0];
  assign dir   = cmd_q[1];

  bmdma_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_stat),
    .wr_clr     (wdata[2:1]),
    .wr_cap     (wdata[6:5]),
    .hw_active  (hw_active),
    .hw_err_set (hw_err_set),
    .hw_irq_set (hw_irq_set),
    .stat_q     (stat)
  );

  // descriptor pointer with byte-lane merge
  assign lanes    = lane_mask(size, off);
  assign wr_shift = wdata << {off, 3'b000};
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign lane_bits[8*b +: 8] = {8{lanes[b]}};
  end
  assign base_nx = ({base_q, 2'b00} & ~lane_bits) | (wr_shift & lane_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (wr_base) base_q <= base_nx[REG_W-1:2];
  end
  assign base = {base_q, 2'b00};

  always_comb begin
    if (!sub) begin
      if (!byte_acc) begin
        rdata = width_ones(size);
      end else begin
        case (off)
          2'd0:    rdata = {24'h0, 4'h0, cmd_q[1], 2'b00, cmd_q[0]};
          2'd2:    rdata = {24'h0, stat};
          default: rdata = 32'h0000_00FF;
        endcase
      end
    end else begin
      rdata = (base >> {off, 3'b000}) & width_ones(size);
    end
  end

  assert_wide_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && !sub && size != SZ_BYTE) |=> $stable(cmd_q));
  assert_cmd_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && !sub && size == SZ_BYTE && off == 2'd0) |=> (start == $past(wdata[0])));
  assert_unsel_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(cmd_q) && $stable(base_q)));
endmodule

// File: rtl/bmdma_regwin.sv
module bmdma_regwin
  import bmdma_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + $clog2(SLICE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [1:0]              bus_size,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [REG_W-1:0]        bus_wdata,
  output logic [REG_W-1:0]        bus_rdata,
  output logic                    bus_rvalid,
  input  logic [NUM_CH-1:0]       hw_active,
  input  logic [NUM_CH-1:0]       hw_err_set,
  input  logic [NUM_CH-1:0]       hw_irq_set,
  output logic [NUM_CH-1:0]       cmd_start,
  output logic [NUM_CH-1:0]       cmd_dir,
  output logic [NUM_CH*REG_W-1:0] prd_base
);
  logic [CH_W-1:0]   ch_idx;
  logic [NUM_CH-1:0] sel;
  logic [REG_W-1:0]  ch_rd [NUM_CH];
  logic [REG_W-1:0]  rd_mux;

  assign ch_idx = bus_addr[ADDR_W-1:3];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign sel[c] = (ch_idx == CH_W'(c));
    bmdma_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (sel[c]),
      .wr         (bus_wr),
      .sub        (bus_addr[2]),
      .off        (bus_addr[1:0]),
      .size       (bus_size),
      .wdata      (bus_wdata),
      .hw_active  (hw_active[c]),
      .hw_err_set (hw_err_set[c]),
      .hw_irq_set (hw_irq_set[c]),
      .rdata      (ch_rd[c]),
      .start      (cmd_start[c]),
      .dir        (cmd_dir[c]),
      .base       (prd_base[c*REG_W +: REG_W])
    );
  end

  always_comb begin
    rd_mux = '1;
    for (int c = 0; c < NUM_CH; c++)
      if (sel[c]) rd_mux = ch_rd[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assert_decode_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  assert_rvalid_after_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  assert_no_spurious_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
endmodule

// File: tb/test_bmdma_regwin.sv
`timescale 1ns/1ps
module test_bmdma_regwin;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [1:0]  hw_active = '0, hw_err_set = '0, hw_irq_set = '0;
  logic [1:0]  cmd_start, cmd_dir;
  logic [63:0] prd_base;

  int n_checks = 0, n_err = 0;
  bit done = 0;

  logic [1:0]  m_cmd [2];
  logic [1:0]  m_cap [2];
  logic        m_err [2], m_irq [2];
  logic [31:0] m_base [2];

  always #5 clk = ~clk;

  bmdma_regwin #(.NUM_CH(2)) i_bmdma_regwin (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .hw_active(hw_active),
    .hw_err_set(hw_err_set), .hw_irq_set(hw_irq_set), .cmd_start(cmd_start),
    .cmd_dir(cmd_dir), .prd_base(prd_base));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int a, input int sz);
    int ch = a / 8, o = a % 4;
    logic [31:0] ones = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    if ((a % 8) < 4) begin
      if (sz != 0) return ones;
      if (o == 0) return {28'h0, m_cmd[ch][1], 2'b00, m_cmd[ch][0]};
      if (o == 2) return {24'h0, 1'b0, m_cap[ch], 2'b00, m_irq[ch], m_err[ch], hw_active[ch]};
      return 32'hFF;
    end
    return (m_base[ch] >> (8 * o)) & ones;
  endfunction

  task automatic do_write(input int a, input int sz, input logic [31:0] d,
                          input logic [1:0] es, input logic [1:0] is);
    int ch = a / 8, o = a % 4, n;
    @(negedge clk);
    bus_addr = 4'(a); bus_size = 2'(sz); bus_wdata = d; bus_wr = 1'b1;
    hw_err_set = es; hw_irq_set = is;
    @(negedge clk);
    bus_wr = 1'b0; hw_err_set = '0; hw_irq_set = '0;
    if ((a % 8) < 4) begin
      if (sz == 0 && o == 0) m_cmd[ch] = {d[3], d[0]};
      if (sz == 0 && o == 2) begin
        m_cap[ch] = d[6:5];
        m_err[ch] = m_err[ch] & ~d[1];
        m_irq[ch] = m_irq[ch] & ~d[2];
      end
    end else begin
      n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      for (int b = o; b < o + n && b < 4; b++) m_base[ch][8*b +: 8] = d[8*(b-o) +: 8];
      m_base[ch][1:0] = 2'b00;
    end
    for (int c = 0; c < 2; c++) begin
      if (es[c]) m_err[c] = 1'b1;
      if (is[c]) m_irq[c] = 1'b1;
    end
  endtask

  task automatic do_read(input int a, input int sz, output logic [31:0] v);
    @(negedge clk);
    bus_addr = 4'(a); bus_size = 2'(sz); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R10 rvalid", {31'h0, bus_rvalid}, 32'h1);
    v = bus_rdata;
  endtask

  task automatic sweep(input string req);
    logic [31:0] v;
    for (int a = 0; a < 16; a++)
      for (int sz = 0; sz < 3; sz++) begin
        do_read(a, sz, v);
        check(req, v, exp_read(a, sz));
      end
  endtask

  task automatic check_outs(input string req);
    for (int c = 0; c < 2; c++) begin
      check(req, {31'h0, cmd_start[c]}, {31'h0, m_cmd[c][0]});
      check(req, {31'h0, cmd_dir[c]}, {31'h0, m_cmd[c][1]});
      check(req, prd_base[32*c +: 32], m_base[c]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < 2; c++) begin
      m_cmd[c] = '0; m_cap[c] = '0; m_err[c] = 0; m_irq[c] = 0; m_base[c] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1 rvalid in reset", {31'h0, bus_rvalid}, 32'h0);
    check_outs("R1 outputs in reset");
    rst_n = 1'b1;
    sweep("R1 reset readback");

    // R7: command byte, both channels; R9 via the other channel's outputs
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 256; w += 5) begin
        do_write(8 * c, 0, 32'(w), 2'b00, 2'b00);
        check_outs("R7 command outputs");
      end
    sweep("R9 after command writes");

    // R3: wide accesses to command/status bytes are ignored
    do_write(0, 1, 32'hFFFF_FFFF, 2'b00, 2'b00);
    do_write(8, 2, 32'hFFFF_FFFF, 2'b00, 2'b00);
    do_write(2, 2, 32'h0000_0066, 2'b00, 2'b00);
    check_outs("R3 wide write ignored");
    sweep("R3 wide access readback");

    // R2: odd byte offsets of the command/status bytes
    do_write(1, 0, 32'hFF, 2'b00, 2'b00);
    do_write(11, 0, 32'hFF, 2'b00, 2'b00);
    check_outs("R2 odd offset write ignored");
    sweep("R2 decode");

    // R8: pointer lanes at every offset and width
    do_write(4, 2, 32'hDEAD_BEEF, 2'b00, 2'b00);
    check("R8 low bits dropped", prd_base[31:0], 32'hDEAD_BEEC);
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 4; o++)
        for (int sz = 0; sz < 3; sz++) begin
          do_write(8 * c + 4 + o, sz, 32'h9E37_79B9 * 32'(o + 4 * sz + 7 * c + 1), 2'b00, 2'b00);
          check_outs("R8 pointer merge");
        end
    sweep("R8 pointer readback");

    // R4: exhaustive status write with both events armed and activity toggled
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 256; w++) begin
        @(negedge clk);
        hw_active[c] = ~w[0];
        do_write(8 * c + 2, 0, 32'hFF, (c == 0) ? 2'b01 : 2'b10, (c == 0) ? 2'b01 : 2'b10);
        do_write(8 * c + 2, 0, 32'(w), 2'b00, 2'b00);
        do_read(8 * c + 2, 0, v);
        check("R4 status write", v, exp_read(8 * c + 2, 0));
      end
    sweep("R9 after status writes");

    // R5: set beats same-cycle clear, and the other channel clears normally
    do_write(2, 0, 32'h06, 2'b01, 2'b01);
    do_write(10, 0, 32'h06, 2'b11, 2'b11);
    do_write(2, 0, 32'h06, 2'b01, 2'b00);
    do_read(2, 0, v);
    check("R5 set over clear", v, exp_read(2, 0));
    check("R5 err kept", {31'h0, v[1]}, 32'h1);
    check("R5 irq cleared", {31'h0, v[2]}, 32'h0);
    do_read(10, 0, v);
    check("R5 other channel", v, exp_read(10, 0));

    // R6: bit 0 lags hw_active by one edge
    @(negedge clk);
    hw_active = 2'b00;
    @(negedge clk);
    @(negedge clk);
    hw_active[0] = 1'b1;
    bus_addr = 4'd2; bus_size = 2'd0; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R6 bit0 before edge", {31'h0, bus_rdata[0]}, 32'h0);
    do_read(2, 0, v);
    check("R6 bit0 after edge", {31'h0, v[0]}, 32'h1);
    do_read(10, 0, v);
    check("R6 other channel idle", {31'h0, v[0]}, 32'h0);
    sweep("R10 reads have no side effect");
    sweep("R10 repeat read");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule